// File: doc/BRIEF.md
# Serial NOR Flash Slave Model

This block sits on the far side of a four-wire SPI link and answers like a small serial NOR flash. A flash-controller master under test can be exercised against it without a real memory device. It works in SPI mode 0, with the clock idling low. It sees the chip-select, serial-clock and MOSI pins through synchronizers into the system clock domain, and it drives MISO from a register. A byte array of `MEM_BYTES` entries stands in for the 24-bit address space. The upper address bits alias onto it.

Each chip-select frame opens with an opcode byte. The block decodes five operations: set write enable, read status, page program, read data and sector erase. Program and erase run only when the write-enable latch was set, and both clear the latch afterwards. Erase is carried out by a walker that writes 0xFF into one location per clock, so the array stays a plain single-port RAM. The same walker fills the whole array with 0xFF after reset. The busy flag is set while the walker runs and can be read in the status register. The master must hold each SCK half period for at least 4 system clocks.

Top module: `flash_emu`

## Requirements
- R1: After reset, MISO is high and the status busy bit (bit 0) reads 1 while the array is being filled. Once busy clears, every location reads 0xFF and the write-enable latch is 0.
- R2: Data moves MSB first. MOSI is sampled on the rising edge of SCK, and MISO changes only after a falling edge. While the master shifts opcode, address or program-data bytes, or bytes of an ignored frame, MISO returns 0xFF.
- R3: Opcode 0x06 sets the write-enable latch when chip select rises. Opcode 0x05 returns the status byte {6'b0, latch (bit 1), busy (bit 0)} and repeats it, fresh, for every following byte of the frame.
- R4: Opcode 0x03 takes a 24-bit address, MSB byte first. It then returns bytes from consecutive addresses until chip select rises. Only the low log2(MEM_BYTES) address bits select a location.
- R5: Opcode 0x02 with 24-bit address stores each data byte as old AND data. The address increments and wraps inside its PAGE_BYTES page.
- R6: A page program started while the latch is clear changes nothing. A program started with the latch set clears the latch when chip select rises.
- R7: Opcode 0x20 with a full 24-bit address, issued with the latch set, fills the aligned SECTOR_BYTES sector holding the address with 0xFF. It leaves other sectors untouched, sets busy while it runs, and clears the latch. Without the latch it does nothing.
- R8: After any other opcode, the rest of the frame is ignored, including bytes that look like opcodes.
- R9: Raising chip select in the middle of a byte drops the partial byte and resets the bit count, so the next frame decodes normally.
- R10: While busy is set, only the status read executes. Write enable, program, read and erase frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, mode 0 |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, registered |

## Verification
The bench targets a set of corner cases that each catch a specific bug.
- A write enable sent while the reset fill is still busy must not stick. A design that ignores busy would later report a latch of 1.
- A second program of 0xF0 over 0x22 must read back 0x20. A design that overwrites the byte returns 0xF0.
- A two-byte program starting at the last byte of a page must put its second byte at the start of the same page. The first byte of the next page must stay 0xFF.
- An erase must clear only the target sector. A byte written in the next sector must survive.
- A frame aborted after four bits, and a 0x06 hidden behind an unknown opcode, must both leave the latch clear. A bit counter that is not reset would misdecode the next frame, and a decoder that re-arms would set the latch.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_ERASE = 8'h20;

  typedef enum logic [2:0] {
    FS_OPCODE, FS_ADDR, FS_PROG_IN, FS_READ_OUT, FS_STATUS, FS_SKIP
  } frame_state_t;

  typedef enum logic [1:0] {
    OPK_NONE, OPK_PROG, OPK_READ, OPK_ERASE
  } op_kind_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic mosi_pin,
  output logic frame_on,
  output logic frame_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_bit
);
  logic [STAGES:0]   cs_pipe;
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] mosi_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_pipe   <= '1;
      sck_pipe  <= '0;
      mosi_pipe <= '0;
    end else begin
      cs_pipe   <= {cs_pipe[STAGES-1:0], cs_n_pin};
      sck_pipe  <= {sck_pipe[STAGES-1:0], sck_pin};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_pin};
    end
  end

  assign frame_on  = ~cs_pipe[STAGES-1];
  assign frame_end = cs_pipe[STAGES-1] & ~cs_pipe[STAGES];
  assign sck_rise  = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sck_fall  = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign mosi_bit  = mosi_pipe[STAGES-1];
endmodule

// File: rtl/flash_byte_mem.sv
module flash_byte_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/flash_frame_ctrl.sv
module flash_frame_ctrl
  import flash_emu_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 32,
  parameter int SECTOR_BYTES = 64,
  localparam int IDX_W = $clog2(MEM_BYTES),
  localparam int PG_W  = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_on,
  input  logic             frame_end,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             mosi_bit,
  input  logic [7:0]       mem_rdata,
  output logic [IDX_W-1:0] mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  output logic             miso
);
  localparam logic [IDX_W-1:0] SEC_MASK = IDX_W'(SECTOR_BYTES - 1);

  frame_state_t st;
  op_kind_t     op;
  logic [2:0]   bit_idx;
  logic [6:0]   rx_sr;
  logic [1:0]   addr_cnt;
  logic [23:0]  addr;
  logic         wel, busy, wren_pend, armed, addr_done;
  logic [7:0]   tx_byte, pdata;
  logic         fetch1, fetch2;
  logic [IDX_W-1:0] er_ptr, er_stop;

  logic        byte_done;
  logic [7:0]  rx_byte;
  logic [23:0] addr_next;
  logic [7:0]  status_byte;
  logic [IDX_W-1:0] sec_base;

  assign byte_done   = frame_on & sck_rise & (bit_idx == 3'd7);
  assign rx_byte     = {rx_sr, mosi_bit};
  assign addr_next   = {addr[15:0], rx_byte};
  assign status_byte = {6'b0, wel, busy};
  assign sec_base    = addr[IDX_W-1:0] & ~SEC_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_OPCODE;
      op        <= OPK_NONE;
      bit_idx   <= '0;
      rx_sr     <= '0;
      addr_cnt  <= '0;
      addr      <= '0;
      wel       <= 1'b0;
      busy      <= 1'b1;
      wren_pend <= 1'b0;
      armed     <= 1'b0;
      addr_done <= 1'b0;
      tx_byte   <= 8'hFF;
      pdata     <= '0;
      fetch1    <= 1'b0;
      fetch2    <= 1'b0;
      er_ptr    <= '0;
      er_stop   <= '1;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 8'hFF;
      miso      <= 1'b1;
    end else begin
      mem_we <= 1'b0;
      fetch2 <= fetch1;
      fetch1 <= 1'b0;

      // erase walker: one location per clock
      if (busy) begin
        mem_we    <= 1'b1;
        mem_addr  <= er_ptr;
        mem_wdata <= 8'hFF;
        if (er_ptr == er_stop) busy <= 1'b0;
        else                   er_ptr <= er_ptr + 1'b1;
      end

      if (!frame_on) begin
        st        <= FS_OPCODE;
        op        <= OPK_NONE;
        bit_idx   <= '0;
        addr_cnt  <= '0;
        armed     <= 1'b0;
        addr_done <= 1'b0;
        wren_pend <= 1'b0;
        tx_byte   <= 8'hFF;
        miso      <= 1'b1;
        if (frame_end) begin
          if (wren_pend && !busy) wel <= 1'b1;
          if (op == OPK_PROG && armed) wel <= 1'b0;
          if (op == OPK_ERASE && armed && addr_done && !busy) begin
            wel     <= 1'b0;
            busy    <= 1'b1;
            er_ptr  <= sec_base;
            er_stop <= sec_base | SEC_MASK;
          end
        end
      end else begin
        if (sck_fall) miso <= tx_byte[~bit_idx];
        if (sck_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_bit};
          bit_idx <= bit_idx + 1'b1;
        end
        if (byte_done) begin
          case (st)
            FS_OPCODE: begin
              case (rx_byte)
                OPC_WREN: begin
                  st <= FS_SKIP;
                  if (!busy) wren_pend <= 1'b1;
                end
                OPC_RDSR: begin
                  st      <= FS_STATUS;
                  tx_byte <= status_byte;
                end
                OPC_PROG: begin
                  if (!busy) begin
                    st    <= FS_ADDR;
                    op    <= OPK_PROG;
                    armed <= wel;
                  end else st <= FS_SKIP;
                end
                OPC_READ: begin
                  if (!busy) begin
                    st <= FS_ADDR;
                    op <= OPK_READ;
                  end else st <= FS_SKIP;
                end
                OPC_ERASE: begin
                  if (!busy) begin
                    st    <= FS_ADDR;
                    op    <= OPK_ERASE;
                    armed <= wel;
                  end else st <= FS_SKIP;
                end
                default: st <= FS_SKIP;
              endcase
            end
            FS_ADDR: begin
              addr     <= addr_next;
              addr_cnt <= addr_cnt + 1'b1;
              if (addr_cnt == 2'd2) begin
                case (op)
                  OPK_READ: begin
                    st       <= FS_READ_OUT;
                    mem_addr <= addr_next[IDX_W-1:0];
                    fetch1   <= 1'b1;
                  end
                  OPK_PROG: st <= FS_PROG_IN;
                  OPK_ERASE: begin
                    st        <= FS_SKIP;
                    addr_done <= 1'b1;
                  end
                  default: st <= FS_SKIP;
                endcase
              end
            end
            FS_PROG_IN: begin
              if (armed) begin
                pdata    <= rx_byte;
                mem_addr <= addr[IDX_W-1:0];
                fetch1   <= 1'b1;
              end
            end
            FS_READ_OUT: begin
              mem_addr <= addr[IDX_W-1:0];
              fetch1   <= 1'b1;
            end
            FS_STATUS: tx_byte <= status_byte;
            default: ;
          endcase
        end
        if (fetch2) begin
          if (st == FS_READ_OUT) begin
            tx_byte <= mem_rdata;
            addr    <= addr + 1'b1;
          end else if (st == FS_PROG_IN) begin
            mem_we    <= 1'b1;
            mem_wdata <= mem_rdata & pdata;
            addr      <= {addr[23:PG_W], addr[PG_W-1:0] + 1'b1};
          end
        end
      end
    end
  end

  AST_MISO_FF_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (frame_on && sck_fall && st inside {FS_OPCODE, FS_ADDR, FS_PROG_IN, FS_SKIP}) |=> miso); // R2
  AST_WEL_SET_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(frame_end)); // R3
  AST_PROG_WRITE_ARMED: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wdata != 8'hFF) |-> armed); // R6
  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel)); // R7
  AST_BUSY_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (busy && frame_on) |-> !(st inside {FS_ADDR, FS_PROG_IN, FS_READ_OUT})); // R10
endmodule

// File: rtl/flash_emu.sv
module flash_emu #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 32,
  parameter int SECTOR_BYTES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int IDX_W = $clog2(MEM_BYTES);

  logic frame_on, frame_end, sck_rise, sck_fall, mosi_bit;
  logic [IDX_W-1:0] mem_addr;
  logic             mem_we;
  logic [7:0]       mem_wdata, mem_rdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n_pin(spi_cs_n), .sck_pin(spi_sck), .mosi_pin(spi_mosi),
    .frame_on(frame_on), .frame_end(frame_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_bit)
  );

  flash_frame_ctrl #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .frame_on(frame_on), .frame_end(frame_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_bit),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .miso(spi_miso)
  );

  flash_byte_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .addr(mem_addr), .we(mem_we),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: tb/flash_emu_test.sv
module flash_emu_test;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  always #5 clk = ~clk;

  flash_emu uut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_v[$];
  string      exp_r[$];
  logic [7:0] got_q[$];
  logic [7:0] tq[$];
  logic [7:0] eq[$];
  logic [7:0] last_rx;

  // monitor: compares produced bytes against the expected queue
  initial begin
    forever begin
      wait (got_q.size() > 0);
      begin
        logic [7:0] g, e;
        string r;
        g = got_q.pop_front();
        e = exp_v.pop_front();
        r = exp_r.pop_front();
        checks++;
        if (g !== e) begin
          fails++;
          $display("FAIL %s: got %02h expected %02h", r, g, e);
        end
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (HALF - 1) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // driver: pushes expectations then shifts the frame held in tq/eq
  task automatic frame(input string req, input bit chk);
    logic [7:0] rx;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    foreach (tq[k]) begin
      if (chk) begin
        exp_v.push_back(eq[k]);
        exp_r.push_back(req);
      end
      xfer(tq[k], rx);
      last_rx = rx;
      if (chk) got_q.push_back(rx);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 40; n++) begin
      tq = '{8'h05, 8'h00};
      frame("poll", 1'b0);
      if (last_rx[0] == 1'b0) break;
    end
  endtask

  task automatic wren();
    tq = '{8'h06}; eq = '{8'hFF};
    frame("R3 wren", 1'b1);
  endtask

  task automatic rd1(input logic [23:0] a, input logic [7:0] e, input string req);
    tq = '{8'h03, a[23:16], a[15:8], a[7:0], 8'h00};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, e};
    frame(req, 1'b1);
  endtask

  task automatic stat(input logic [7:0] e, input string req);
    tq = '{8'h05, 8'h00}; eq = '{8'hFF, e};
    frame(req, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (miso !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset miso: got %b expected 1", miso);
    end
    rst = 1'b0;
    // R10: write enable while reset fill is busy must be dropped
    tq = '{8'h06}; eq = '{8'hFF};
    frame("R10 wren busy", 1'b1);
    stat(8'h01, "R1 busy after reset");
    wait_ready();
    stat(8'h00, "R10 wren ignored while busy");
    rd1(24'h000010, 8'hFF, "R1 erased after reset");

    // R6: program without latch
    tq = '{8'h02, 8'h00, 8'h00, 8'h01, 8'h22};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 prog no wel", 1'b1);
    rd1(24'h000001, 8'hFF, "R6 no change without wel");

    wren();
    tq = '{8'h05, 8'h00, 8'h00}; eq = '{8'hFF, 8'h02, 8'h02};
    frame("R3 status repeat", 1'b1);

    tq = '{8'h02, 8'h00, 8'h00, 8'h01, 8'h22};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 prog phase", 1'b1);
    stat(8'h00, "R6 wel cleared");
    rd1(24'h000001, 8'h22, "R5 program 22");

    wren();
    tq = '{8'h02, 8'h00, 8'h00, 8'h01, 8'hF0};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 prog and", 1'b1);
    rd1(24'h000001, 8'h20, "R5 and semantics");

    wren();
    tq = '{8'h02, 8'h00, 8'h00, 8'h1F, 8'h11, 8'h33};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 prog wrap", 1'b1);
    tq = '{8'h03, 8'h00, 8'h00, 8'h1F, 8'h00, 8'h00};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h11, 8'hFF};
    frame("R5 page wrap end", 1'b1);
    tq = '{8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h33, 8'h20};
    frame("R4 sequential read", 1'b1);
    rd1(24'hABCD01, 8'h20, "R4 address alias");

    wren();
    tq = '{8'h02, 8'h00, 8'h00, 8'h40, 8'h5A};
    eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 prog sector1", 1'b1);
    rd1(24'h000040, 8'h5A, "R5 program sector1");

    // R7: erase without latch
    tq = '{8'h20, 8'h00, 8'h00, 8'h05}; eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 erase no wel", 1'b1);
    wait_ready();
    rd1(24'h000001, 8'h20, "R7 erase without wel");

    wren();
    tq = '{8'h20, 8'h00, 8'h00, 8'h05}; eq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    frame("R2 erase", 1'b1);
    wait_ready();
    stat(8'h00, "R7 wel cleared by erase");
    rd1(24'h000001, 8'hFF, "R7 sector erased");
    rd1(24'h00001F, 8'hFF, "R7 sector end erased");
    rd1(24'h000040, 8'h5A, "R7 next sector kept");

    // R8: unknown opcode hides a write enable
    tq = '{8'h9F, 8'h06, 8'h00}; eq = '{8'hFF, 8'hFF, 8'hFF};
    frame("R8 unknown opcode", 1'b1);
    stat(8'h00, "R8 no latch after unknown");

    // R9: abort after four bits
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    begin
      logic [7:0] junk;
      junk = 8'h00;
      for (int i = 7; i >= 4; i--) begin
        @(negedge clk) mosi = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        junk[i] = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    stat(8'h00, "R9 decode after abort");
    wren();
    stat(8'h02, "R9 wren after abort");

    wait (got_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule